// File: doc/BRIEF.md
# Timekeeping Register Window over Byte-Wide RAM

This block is a byte-wide, SRAM-style slave. It decodes a chip-select pair, an output enable and a write enable. The lowest locations of its address space map to an internal byte array. The eight highest locations form a timekeeping register window. That window does not show the live calendar counters directly. It shows a shadow copy, which either tracks the counters, stays frozen for a consistent read, or is opened for editing.

The calendar counter is a separate block. It feeds its current values into `live_time_i`. It takes new values from `load_time_o` whenever `load_o` pulses. A power-good input stands in for supply sensing. While that input is low, every bus access is ignored and the reset output is driven low. A prescaler supplies a 512 Hz strobe for the frequency-test feature.

The top two bits of the control byte select the shadow mode. After a frozen or edited phase ends, the shadow refresh waits `HOLD_CYC` system clock cycles. This models the minimum settle time before new counter values are guaranteed to appear.

Top module: `rtc_timekeep_regs`

## Requirements
- R1: Addresses below the top eight locations of the 2^AW byte space read back the last byte written there.
- R2: `rdata_oe_o` is high only when `sel_ni`=0, `sel2_i`=1, `oe_ni`=0, `wr_ni`=1 and power is good. Whenever `rdata_oe_o` is low, `rdata_o` is 0.
- R3: A write takes effect on the rising clock edge only when `sel_ni`=0, `sel2_i`=1 and `wr_ni`=0. With any other strobe combination, storage is unchanged.
- R4: While `pwr_good_i`=0, no read or write happens and `pwr_fail_no` is 0. Otherwise `pwr_fail_no` is 1.
- R5: The window offsets are 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. Byte `i` of `live_time_i`/`load_time_o` sits at bits [8i+7:8i]. The clock-field masks are 3F, 7F, 7F, 3F, 07, 3F, 1F and FF. While both mode bits are 0 and the hold count has elapsed, the masked fields copy `live_time_i` every cycle.
- R6: While control bit 6 (freeze) is 1, the shadow clock fields keep the values taken on the edge that set the bit.
- R7: After both control bits 7 and 6 return to 0, no refresh happens until `HOLD_CYC` more cycles have passed. Then all eight bytes refresh together.
- R8: While control bit 7 (edit) is 1, the shadow does not refresh, and written bytes are kept. Writing 0 to bit 7 while it is 1 raises `load_o` for exactly one cycle, starting the cycle after the write. During that cycle `load_time_o` carries the masked shadow bytes.
- R9: Seconds bit 7 is the oscillator stop control and appears on `osc_stop_o`.
- R10: Day bit 6 is the frequency-test control and appears on `freq_test_o`. While it is 1 and seconds bit 7 is 0, seconds bit 0 reads a phase that starts at 0 and toggles on each `tick_512_i` strobe.
- R11: Day bit 7 always reads `batt_ok_i`, and writes to that bit have no visible effect.
- R12: Window bits outside the clock-field masks behave as plain storage and survive refresh.
- R13: After reset, all shadow bytes are 0, both mode bits are 0, `load_o` is 0 and the hold count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply within tolerance |
| sel_ni | input | 1 | Chip select, active low |
| sel2_i | input | 1 | Second chip select, active high |
| oe_ni | input | 1 | Output enable, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | AW | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not driving |
| rdata_oe_o | output | 1 | Read data valid / bus drive enable |
| pwr_fail_no | output | 1 | Power-fail reset, active low |
| live_time_i | input | 64 | Live counter bytes from the calendar block |
| tick_512_i | input | 1 | 512 Hz strobe, one cycle wide |
| batt_ok_i | input | 1 | Battery level good |
| load_o | output | 1 | One-cycle load strobe to the calendar block |
| load_time_o | output | 64 | Masked shadow bytes to load |
| osc_stop_o | output | 1 | Oscillator stop request |
| freq_test_o | output | 1 | Frequency-test mode enable |

## Verification
The shadow is driven through four patterns, and each one separates a different mode. In the tracking pattern the counters change freely, which shows that refresh runs and that plain-storage bits survive it. In the freeze pattern the counters change while bit 6 is set, which separates a held shadow from one that is still tracking. The release pattern reads the shadow both inside and after the hold window, which separates an immediate refresh from a deferred one. The edit-and-commit pattern checks that written values reach `load_time_o` with a one-cycle strobe, and then return through the counters.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned DW   = 8;

  typedef logic [DW-1:0] byte_t;

  localparam logic [2:0] OFF_CTRL  = 3'd0;
  localparam logic [2:0] OFF_SEC   = 3'd1;
  localparam logic [2:0] OFF_DAY   = 3'd4;

  localparam int unsigned CTRL_EDIT_BIT = 7;
  localparam int unsigned CTRL_FRZ_BIT  = 6;
  localparam int unsigned SEC_STOP_BIT  = 7;
  localparam int unsigned DAY_FT_BIT    = 6;
  localparam int unsigned DAY_BATT_BIT  = 7;

  // bits owned by the calendar counter; the rest are plain storage or control
  function automatic byte_t clk_field_mask(input logic [2:0] off);
    case (off)
      3'd0:    return 8'h3F;
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tk_decode.sv
module rtc_tk_decode #(
  parameter int unsigned AW = 11
) (
  input  logic          pwr_good_i,
  input  logic          sel_ni,
  input  logic          sel2_i,
  input  logic          oe_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  output logic          wr_o,
  output logic          rd_o,
  output logic          win_o,
  output logic [2:0]    off_o
);
  logic acc;

  assign acc   = pwr_good_i & ~sel_ni & sel2_i;
  assign wr_o  = acc & ~wr_ni;
  assign rd_o  = acc & ~oe_ni & wr_ni;
  assign win_o = &addr_i[AW-1:3];
  assign off_o = addr_i[2:0];
endmodule

// File: rtl/rtc_tk_ram.sv
module rtc_tk_ram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/rtc_tk_shadow.sv
module rtc_tk_shadow
  import rtc_tk_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 25000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 win_i,
  input  logic [2:0]           off_i,
  input  byte_t                wdata_i,
  input  logic [NREG*DW-1:0]   live_i,
  input  logic                 tick_512_i,
  input  logic                 batt_ok_i,
  output byte_t                rd_byte_o,
  output logic                 load_o,
  output logic [NREG*DW-1:0]   load_time_o,
  output logic                 osc_stop_o,
  output logic                 freq_test_o,
  output logic                 edit_o,
  output logic                 frz_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  byte_t          sh_q [NREG];
  logic [CW-1:0]  hold_q;
  logic           edit, frz, refresh, ft_live, phase_q, load_q, ctrl_wr;

  assign edit    = sh_q[OFF_CTRL][CTRL_EDIT_BIT];
  assign frz     = sh_q[OFF_CTRL][CTRL_FRZ_BIT];
  assign refresh = ~edit & ~frz & (hold_q == CW'(HOLD_CYC));
  assign ctrl_wr = wr_i & win_i & (off_i == OFF_CTRL);

  // settle counter: restarts while either mode bit is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= '0;
    else if (edit | frz)             hold_q <= '0;
    else if (hold_q != CW'(HOLD_CYC)) hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) sh_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_i && win_i && off_i == 3'(i))
          sh_q[i] <= wdata_i;
        else if (refresh)
          sh_q[i] <= (sh_q[i] & ~clk_field_mask(3'(i))) |
                     (live_i[DW*i +: DW] & clk_field_mask(3'(i)));
      end
    end
  end

  // commit strobe on the edit bit's falling write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= edit & ctrl_wr & ~wdata_i[CTRL_EDIT_BIT];
  end

  assign ft_live = sh_q[OFF_DAY][DAY_FT_BIT] & ~sh_q[OFF_SEC][SEC_STOP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= 1'b0;
    else if (!ft_live)   phase_q <= 1'b0;
    else if (tick_512_i) phase_q <= ~phase_q;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_load
    assign load_time_o[DW*g +: DW] = sh_q[g] & clk_field_mask(3'(g));
  end

  always_comb begin
    rd_byte_o = sh_q[off_i];
    if (off_i == OFF_SEC && ft_live) rd_byte_o[0] = phase_q;
    if (off_i == OFF_DAY)            rd_byte_o[DAY_BATT_BIT] = batt_ok_i;
  end

  assign load_o      = load_q;
  assign osc_stop_o  = sh_q[OFF_SEC][SEC_STOP_BIT];
  assign freq_test_o = sh_q[OFF_DAY][DAY_FT_BIT];
  assign edit_o      = edit;
  assign frz_o       = frz;
endmodule

// File: rtl/rtc_timekeep_regs.sv
module rtc_timekeep_regs
  import rtc_tk_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter int unsigned HOLD_CYC = 25000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_good_i,
  input  logic                 sel_ni,
  input  logic                 sel2_i,
  input  logic                 oe_ni,
  input  logic                 wr_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 rdata_oe_o,
  output logic                 pwr_fail_no,
  input  logic [63:0]          live_time_i,
  input  logic                 tick_512_i,
  input  logic                 batt_ok_i,
  output logic                 load_o,
  output logic [63:0]          load_time_o,
  output logic                 osc_stop_o,
  output logic                 freq_test_o
);
  logic       bus_wr, bus_rd, win;
  logic [2:0] off;
  byte_t      ram_rd, win_rd;
  logic       edit, frz;

  rtc_tk_decode #(.AW(AW)) u_dec (
    .pwr_good_i(pwr_good_i), .sel_ni(sel_ni), .sel2_i(sel2_i),
    .oe_ni(oe_ni), .wr_ni(wr_ni), .addr_i(addr_i),
    .wr_o(bus_wr), .rd_o(bus_rd), .win_o(win), .off_o(off)
  );

  rtc_tk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i(clk_i), .we_i(bus_wr & ~win), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(ram_rd)
  );

  rtc_tk_shadow #(.HOLD_CYC(HOLD_CYC)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr), .win_i(win), .off_i(off),
    .wdata_i(wdata_i), .live_i(live_time_i), .tick_512_i(tick_512_i),
    .batt_ok_i(batt_ok_i), .rd_byte_o(win_rd), .load_o(load_o),
    .load_time_o(load_time_o), .osc_stop_o(osc_stop_o),
    .freq_test_o(freq_test_o), .edit_o(edit), .frz_o(frz)
  );

  assign rdata_oe_o  = bus_rd;
  assign rdata_o     = bus_rd ? (win ? win_rd : ram_rd) : '0;
  assign pwr_fail_no = pwr_good_i;
endmodule

// File: rtl/rtc_timekeep_regs_chk.sv
module rtc_timekeep_regs_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_good_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    rdata_o,
  input logic          rdata_oe_o,
  input logic          pwr_fail_no,
  input logic          batt_ok_i,
  input logic          load_o,
  input logic [63:0]   load_time_o,
  input logic          bus_wr,
  input logic          edit,
  input logic          frz
);
  assert_no_access_pwr_bad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (!rdata_oe_o && !pwr_fail_no && !bus_wr));

  assert_idle_bus_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> rdata_o == 8'h00);

  assert_load_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_load_after_edit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> ($past(edit) && !edit));

  assert_freeze_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frz) && !$past(bus_wr)) |-> $stable(load_time_o));

  assert_batt_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && (&addr_i[AW-1:3]) && addr_i[2:0] == 3'd4) |-> rdata_o[7] == batt_ok_i);
endmodule

bind rtc_timekeep_regs rtc_timekeep_regs_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .pwr_fail_no(pwr_fail_no),
  .batt_ok_i(batt_ok_i), .load_o(load_o), .load_time_o(load_time_o),
  .bus_wr(bus_wr), .edit(edit), .frz(frz)
);

// File: tb/tb_rtc_timekeep_regs.sv
module tb_rtc_timekeep_regs;
  localparam int AW   = 11;
  localparam int HOLD = 16;
  localparam int WB   = (1 << AW) - 8;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic pwr_good, sel_n, sel2, oe_n, we_n, tick, batt_ok;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  logic rdata_oe, pwr_fail_n, load, osc_stop, freq_test;
  logic [63:0] live, load_time;

  int checks = 0, errors = 0;
  bit done = 0;

  rtc_timekeep_regs #(.AW(AW), .HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .sel_ni(sel_n),
    .sel2_i(sel2), .oe_ni(oe_n), .wr_ni(we_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .pwr_fail_no(pwr_fail_n),
    .live_time_i(live), .tick_512_i(tick), .batt_ok_i(batt_ok),
    .load_o(load), .load_time_o(load_time), .osc_stop_o(osc_stop),
    .freq_test_o(freq_test)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] msk(input int i);
    case (i)
      0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
      4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
    endcase
  endfunction

  // behavioural reference model
  logic [7:0] m_sh [8];
  logic [7:0] nsh [8];
  logic [7:0] m_ram [1 << AW];
  bit m_vld [1 << AW];
  int m_hold;
  bit m_load, m_phase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_sh[i]) m_sh[i] = 8'h00;
      foreach (m_vld[i]) m_vld[i] = 0;
      m_hold = 0; m_load = 0; m_phase = 0;
    end else begin
      bit bw, inwin, ren, ed, fz, ftl;
      int off;
      bw    = pwr_good && !sel_n && sel2 && !we_n;
      inwin = (int'(addr) >= WB);
      off   = int'(addr) - WB;
      ed    = m_sh[0][7];
      fz    = m_sh[0][6];
      ren   = !ed && !fz && (m_hold == HOLD);
      ftl   = m_sh[4][6] && !m_sh[1][7];
      for (int i = 0; i < 8; i++) begin
        nsh[i] = m_sh[i];
        if (bw && inwin && off == i) nsh[i] = wdata;
        else if (ren) nsh[i] = (m_sh[i] & ~msk(i)) | (live[8*i +: 8] & msk(i));
      end
      m_load  = ed && bw && inwin && off == 0 && !wdata[7];
      m_hold  = (ed || fz) ? 0 : ((m_hold < HOLD) ? m_hold + 1 : m_hold);
      m_phase = ftl ? (tick ? !m_phase : m_phase) : 1'b0;
      if (bw && !inwin) begin m_ram[addr] = wdata; m_vld[addr] = 1; end
      for (int i = 0; i < 8; i++) m_sh[i] = nsh[i];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_oe;
      logic [7:0] e;
      logic [63:0] flat;
      int off;
      exp_oe = pwr_good && !sel_n && sel2 && !oe_n && we_n;
      chk("R2 read enable", 64'(rdata_oe), 64'(exp_oe));
      if (!exp_oe) chk("R2 idle bus", 64'(rdata), 64'h0);
      else if (int'(addr) >= WB) begin
        off = int'(addr) - WB;
        e = m_sh[off];
        if (off == 1 && m_sh[4][6] && !m_sh[1][7]) e[0] = m_phase;
        if (off == 4) e[7] = batt_ok;
        chk("R5 window read", 64'(rdata), 64'(e));
      end else if (m_vld[addr]) chk("R1 ram read", 64'(rdata), 64'(m_ram[addr]));
      for (int i = 0; i < 8; i++) flat[8*i +: 8] = m_sh[i] & msk(i);
      chk("R8 load strobe", 64'(load), 64'(m_load));
      chk("R8 load data", load_time, flat);
      chk("R9 osc stop", 64'(osc_stop), 64'(m_sh[1][7]));
      chk("R10 freq test", 64'(freq_test), 64'(m_sh[4][6]));
      chk("R4 reset out", 64'(pwr_fail_n), 64'(pwr_good));
    end
  end

  // calendar stand-in adopts committed values
  always @(posedge clk) if (load) live <= load_time;

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_wr(input int a, input logic [7:0] d);
    addr = AW'(a); wdata = d; sel_n = 0; sel2 = 1; we_n = 0; oe_n = 1;
    @(posedge clk); #2;
    sel_n = 1; we_n = 1;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    addr = AW'(a); sel_n = 0; sel2 = 1; we_n = 1; oe_n = 0;
    @(negedge clk); d = rdata;
    @(posedge clk); #2;
    sel_n = 1; oe_n = 1;
  endtask

  task automatic tick_pulse();
    tick = 1; @(posedge clk); #2; tick = 0;
  endtask

  initial begin
    logic [7:0] d;
    sel_n = 1; sel2 = 0; oe_n = 1; we_n = 1; addr = '0; wdata = '0;
    pwr_good = 1; tick = 0; batt_ok = 1;
    live = {8'h24, 8'h02, 8'h28, 8'h03, 8'h13, 8'h30, 8'h45, 8'h20};
    repeat (3) @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk("R13 load idle", 64'(load), 64'h0);
    chk("R13 osc stop clear", 64'(osc_stop), 64'h0);
    @(posedge clk); #2;
    bus_rd(WB + 0, d); chk("R13 ctrl reset", 64'(d), 64'h00);
    bus_rd(WB + 1, d); chk("R13 seconds reset", 64'(d), 64'h00);

    bus_wr(5, 8'hA5); bus_wr(WB - 1, 8'h3C);
    bus_rd(5, d);      chk("R1 ram low", 64'(d), 64'hA5);
    bus_rd(WB - 1, d); chk("R1 ram top", 64'(d), 64'h3C);

    addr = AW'(5); wdata = 8'h11; sel_n = 0; sel2 = 0; we_n = 0;
    @(posedge clk); #2;
    sel_n = 1; sel2 = 1; wdata = 8'h22;
    @(posedge clk); #2;
    we_n = 1;
    bus_rd(5, d); chk("R3 write gated", 64'(d), 64'hA5);

    addr = AW'(5); sel_n = 0; sel2 = 1; oe_n = 1; we_n = 1;
    @(negedge clk); chk("R2 no oe", 64'({rdata_oe, rdata}), 64'h0);
    sel2 = 0; oe_n = 0;
    @(negedge clk); chk("R2 sel2 low", 64'({rdata_oe, rdata}), 64'h0);
    @(posedge clk); #2; sel_n = 1; oe_n = 1; sel2 = 1;

    pwr_good = 0;
    bus_wr(5, 8'hFF);
    addr = AW'(5); sel_n = 0; oe_n = 0;
    @(negedge clk);
    chk("R4 read blocked", 64'(rdata_oe), 64'h0);
    chk("R4 reset low", 64'(pwr_fail_n), 64'h0);
    @(posedge clk); #2; sel_n = 1; oe_n = 1; pwr_good = 1;
    bus_rd(5, d); chk("R4 write blocked", 64'(d), 64'hA5);

    idle(HOLD + 4);
    bus_rd(WB + 1, d); chk("R5 seconds", 64'(d), 64'h45);
    bus_rd(WB + 7, d); chk("R5 year", 64'(d), 64'h24);
    bus_rd(WB + 0, d); chk("R5 century", 64'(d), 64'h20);

    bus_wr(WB + 3, 8'hC0); idle(1);
    bus_rd(WB + 3, d); chk("R12 storage bits kept", 64'(d), 64'hD3);

    bus_wr(WB + 0, 8'h60);
    live[15:8] = 8'h50;
    idle(5);
    bus_rd(WB + 1, d); chk("R6 frozen seconds", 64'(d), 64'h45);
    bus_rd(WB + 0, d); chk("R6 ctrl readback", 64'(d), 64'h60);

    bus_wr(WB + 0, 8'h20);
    bus_rd(WB + 1, d); chk("R7 within hold", 64'(d), 64'h45);
    idle(HOLD + 2);
    bus_rd(WB + 1, d); chk("R7 after hold", 64'(d), 64'h50);

    bus_wr(WB + 0, 8'hA0);
    bus_wr(WB + 1, 8'h07);
    bus_wr(WB + 7, 8'h99);
    live[15:8] = 8'h55;
    idle(3);
    bus_rd(WB + 1, d); chk("R8 edit holds", 64'(d), 64'h07);
    bus_wr(WB + 0, 8'h21);
    @(negedge clk);
    chk("R8 strobe high", 64'(load), 64'h1);
    chk("R8 ctrl byte", 64'(load_time[7:0]), 64'h21);
    chk("R8 seconds byte", 64'(load_time[15:8]), 64'h07);
    chk("R8 year byte", 64'(load_time[63:56]), 64'h99);
    @(posedge clk); #2;
    @(negedge clk); chk("R8 strobe single", 64'(load), 64'h0);
    idle(HOLD + 4);
    bus_rd(WB + 1, d); chk("R8 committed value returns", 64'(d), 64'h07);

    bus_wr(WB + 1, 8'h87); idle(1);
    @(negedge clk); chk("R9 stop set", 64'(osc_stop), 64'h1);
    @(posedge clk); #2;
    bus_rd(WB + 1, d); chk("R9 stop bit kept", 64'(d), 64'h87);
    bus_wr(WB + 1, 8'h07); idle(1);

    bus_wr(WB + 4, 8'h40); idle(1);
    @(negedge clk); chk("R10 test on", 64'(freq_test), 64'h1);
    @(posedge clk); #2;
    bus_rd(WB + 1, d); chk("R10 phase 0", 64'(d), 64'h06);
    tick_pulse();
    bus_rd(WB + 1, d); chk("R10 phase 1", 64'(d), 64'h07);
    tick_pulse();
    bus_rd(WB + 1, d); chk("R10 phase back", 64'(d), 64'h06);

    batt_ok = 0;
    bus_rd(WB + 4, d); chk("R11 battery low", 64'(d), 64'h43);
    batt_ok = 1;
    bus_rd(WB + 4, d); chk("R11 battery good", 64'(d), 64'hC3);
    bus_wr(WB + 4, 8'h00); idle(1);
    bus_rd(WB + 4, d); chk("R11 flag not writable", 64'(d), 64'h83);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1-path stalled: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule